// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Pump/Pin Output Select

This block compares two edge streams that share one system clock: a divided reference strobe and a divided feedback (oscillator) strobe. Each strobe sets one of two internal detector states. Once both states are set, a short delay of a fixed number of clocks clears them together. This keeps a minimum overlap pulse, so small phase errors are not lost. The state that was set first stays active longer. Its extra width, in clocks, equals the phase lead.

A mode input routes the result. In pin mode, two active-low pulse outputs carry the detector states and the pump enable is off, which means the external pump output is tri-stated. In pump mode, the pump enable is on, the two detector pins are held low, and two active-high pump drive lines carry the states.

A digital lock filter watches the raw error, which is the NAND of the two detector outputs before any forcing. It measures the error width of every comparison. It reports lock on an open-drain-style output: the output is released after enough consecutive narrow comparisons, and it is pulled low otherwise.

Top module: `pfd_sel_top`

## Requirements
- R1: A `ref_stb` pulse sets the up state, and `up_n` goes low in the cycle after the strobe (pin mode, `pump_mode`=0).
- R2: A `fb_stb` pulse sets the down state, and `dn_n` goes low in the cycle after the strobe (pin mode).
- R3: While both states are set, they stay set for exactly `RST_DLY` cycles and then both clear together. For a lead of L cycles, the leading output is active for L+`RST_DLY` cycles and the lagging one for `RST_DLY` cycles. Simultaneous strobes give two pulses of `RST_DLY` cycles each.
- R4: A strobe that arrives while its own state is already set, or while both states are set (including the clearing cycle), has no effect.
- R5: With `pump_mode`=1, `up_n` and `dn_n` are held at 0, `pump_en` is 1, and `pump_up`/`pump_dn` are high exactly while the up/down states are set.
- R6: With `pump_mode`=0, `pump_en`, `pump_up` and `pump_dn` are all 0.
- R7: The error width of a comparison is the number of cycles in which exactly one state is set, which equals the lead L. The comparison counts as narrow when L ≤ `LOCK_THR`. The error is measured from the internal states, so it is measured the same way in both modes.
- R8: `lock_pull_low` is released (0) once `LOCK_CNT` consecutive narrow comparisons have completed, and is 1 before that. It can only change in the cycle after a joint clear.
- R9: A comparison wider than `LOCK_THR` resets the count, and `lock_pull_low` returns to 1.
- R10: After reset, `up_n`=`dn_n`=1, `pump_up`=`pump_dn`=0, and `lock_pull_low`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | Single-cycle divided reference edge |
| fb_stb | input | 1 | Single-cycle divided feedback edge |
| pump_mode | input | 1 | 1 selects charge-pump drive, 0 selects detector pins |
| up_n | output | 1 | Active-low up pulse (held 0 in pump mode) |
| dn_n | output | 1 | Active-low down pulse (held 0 in pump mode) |
| pump_en | output | 1 | Charge pump enabled; 0 means pump output tri-stated |
| pump_up | output | 1 | Pump source request, active high |
| pump_dn | output | 1 | Pump sink request, active high |
| lock_pull_low | output | 1 | 1 drives the lock line low (unlocked), 0 releases it |

## Verification
The assertions assume that both strobes are synchronous to `clk` and are driven away from the active edge. They also assume that `pump_mode` changes only between comparisons, so a pulse is never split across modes. The bench drives every input on the falling edge. It sweeps leads in both directions with `pump_mode` fixed for each whole comparison, and it leaves idle cycles after every joint clear. Strobes that must be ignored are placed on purpose while a state is already set and inside the clearing cycle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic {
        MODE_PINS = 1'b0,
        MODE_PUMP = 1'b1
    } pfd_mode_e;

    typedef struct packed {
        logic up_n;
        logic dn_n;
        logic pump_en;
        logic pump_up;
        logic pump_dn;
    } pfd_drive_t;

endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
    parameter int RST_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_stb,
    input  logic fb_stb,
    output logic up_o,
    output logic dn_o,
    output logic clr_o
);
    localparam int DLY_W = (RST_DLY > 1) ? $clog2(RST_DLY) : 1;
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(RST_DLY - 1);

    typedef struct packed {
        logic             up;
        logic             dn;
        logic [DLY_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = 1'b0;
        if (st_q.up && st_q.dn) begin
            // overlap: strobes ignored, count down the joint reset delay
            if (st_q.cnt == DLY_LAST) begin
                clr_d = 1'b1;
                st_d  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            if (ref_stb) st_d.up = 1'b1;
            if (fb_stb)  st_d.dn = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_o  = st_q.up;
    assign dn_o  = st_q.dn;
    assign clr_o = clr_d;
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
    parameter int LOCK_THR = 3,
    parameter int LOCK_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_i,
    input  logic clr_i,
    output logic lock_o
);
    localparam int WID_MAX = LOCK_THR + 1;
    localparam int WID_W   = $clog2(WID_MAX + 1);
    localparam int GOOD_W  = $clog2(LOCK_CNT + 1);
    localparam logic [WID_W-1:0]  WID_SAT  = WID_W'(WID_MAX);
    localparam logic [WID_W-1:0]  WID_LIM  = WID_W'(LOCK_THR);
    localparam logic [GOOD_W-1:0] GOOD_TOP = GOOD_W'(LOCK_CNT);

    typedef struct packed {
        logic [WID_W-1:0]  wid;
        logic [GOOD_W-1:0] good;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            if (st_q.wid <= WID_LIM) begin
                if (st_q.good != GOOD_TOP) st_d.good = st_q.good + 1'b1;
            end else begin
                st_d.good = '0;
            end
            st_d.wid = '0;
        end else if (err_i && (st_q.wid != WID_SAT)) begin
            st_d.wid = st_q.wid + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = (st_q.good == GOOD_TOP);
endmodule

// File: rtl/pfd_out_sel.sv
module pfd_out_sel
    import pfd_pkg::*;
(
    input  pfd_mode_e  mode_i,
    input  logic       up_i,
    input  logic       dn_i,
    output pfd_drive_t drv_o
);
    always_comb begin
        drv_o = '{up_n: 1'b1, dn_n: 1'b1, pump_en: 1'b0, pump_up: 1'b0, pump_dn: 1'b0};
        if (mode_i == MODE_PUMP) begin
            drv_o.up_n    = 1'b0;
            drv_o.dn_n    = 1'b0;
            drv_o.pump_en = 1'b1;
            drv_o.pump_up = up_i;
            drv_o.pump_dn = dn_i;
        end else begin
            drv_o.up_n = ~up_i;
            drv_o.dn_n = ~dn_i;
        end
    end
endmodule

// File: rtl/pfd_sel_top.sv
module pfd_sel_top
    import pfd_pkg::*;
#(
    parameter int RST_DLY  = 2,
    parameter int LOCK_THR = 3,
    parameter int LOCK_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_stb,
    input  logic fb_stb,
    input  logic pump_mode,
    output logic up_n,
    output logic dn_n,
    output logic pump_en,
    output logic pump_up,
    output logic pump_dn,
    output logic lock_pull_low
);
    logic       up_st, dn_st, clr_ev, raw_err, locked;
    pfd_drive_t drv;

    pfd_core #(.RST_DLY(RST_DLY)) core_i (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
        .up_o(up_st), .dn_o(dn_st), .clr_o(clr_ev)
    );

    // NAND of the unforced active-low pins, less the joint overlap
    assign raw_err = ~((~up_st) & (~dn_st)) & ~(up_st & dn_st);

    pfd_lock_filter #(.LOCK_THR(LOCK_THR), .LOCK_CNT(LOCK_CNT)) filt_i (
        .clk(clk), .rst_n(rst_n), .err_i(raw_err), .clr_i(clr_ev), .lock_o(locked)
    );

    pfd_out_sel sel_i (
        .mode_i(pfd_mode_e'(pump_mode)), .up_i(up_st), .dn_i(dn_st), .drv_o(drv)
    );

    assign up_n          = drv.up_n;
    assign dn_n          = drv.dn_n;
    assign pump_en       = drv.pump_en;
    assign pump_up       = drv.pump_up;
    assign pump_dn       = drv.pump_dn;
    assign lock_pull_low = ~locked;
endmodule

// File: rtl/pfd_sel_chk.sv
module pfd_sel_chk #(
    parameter int RST_DLY = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ref_stb,
    input logic fb_stb,
    input logic up_n,
    input logic dn_n,
    input logic pump_en,
    input logic lock_pull_low,
    input logic up_st,
    input logic dn_st
);
    localparam int RUN_W = $clog2(RST_DLY + 2);
    logic [RUN_W-1:0] both_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              both_run_q <= '0;
        else if (up_st && dn_st) both_run_q <= both_run_q + 1'b1;
        else                     both_run_q <= '0;
    end

    a_r1_up_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_st) |-> $past(ref_stb));

    a_r2_dn_needs_fb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_st) |-> $past(fb_stb));

    a_r3_overlap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        both_run_q <= RUN_W'(RST_DLY));

    a_r3_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_st) |-> $fell(dn_st));

    a_r5_pump_holds_pins: assert property (@(posedge clk) disable iff (!rst_n)
        pump_en |-> (!up_n && !dn_n));

    a_r8_lock_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_pull_low != $past(lock_pull_low)) |-> $past(up_st && dn_st));
endmodule

bind pfd_sel_top pfd_sel_chk #(.RST_DLY(RST_DLY)) chk_i (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
    .up_n(up_n), .dn_n(dn_n), .pump_en(pump_en), .lock_pull_low(lock_pull_low),
    .up_st(up_st), .dn_st(dn_st)
);

// File: tb/pfd_sel_top_tb_top.sv
module pfd_sel_top_tb_top;
    localparam int D   = 2;
    localparam int THR = 3;
    localparam int LC  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_stb = 1'b0, fb_stb = 1'b0, pump_mode = 1'b0;
    logic up_n, dn_n, pump_en, pump_up, pump_dn, lock_pull_low;

    int n_cmp = 0;
    int n_bad = 0;
    int good_exp = 0;

    always #5 clk = ~clk;

    pfd_sel_top #(.RST_DLY(D), .LOCK_THR(THR), .LOCK_CNT(LC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
        .pump_mode(pump_mode), .up_n(up_n), .dn_n(dn_n), .pump_en(pump_en),
        .pump_up(pump_up), .pump_dn(pump_dn), .lock_pull_low(lock_pull_low)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // lead: cycles between the two strobes; extra: add strobes that must be ignored (R4)
    task automatic run_cmp(input int lead, input bit ref_first, input bit mode, input bit extra);
        int len = lead + D + 3;
        int up_lo = 0, dn_lo = 0, pu_hi = 0, pd_hi = 0, en_hi = 0;
        int w_up, w_dn;
        pump_mode = mode;
        for (int i = 0; i < len; i++) begin
            logic first_s, second_s;
            first_s  = (i == 0) || (extra && (i == 1 || i == lead + D));
            second_s = (i == lead);
            ref_stb = ref_first ? first_s : second_s;
            fb_stb  = ref_first ? second_s : first_s;
            @(posedge clk);
            @(negedge clk);
            ref_stb = 1'b0;
            fb_stb  = 1'b0;
            up_lo += (up_n == 1'b0) ? 1 : 0;
            dn_lo += (dn_n == 1'b0) ? 1 : 0;
            pu_hi += pump_up ? 1 : 0;
            pd_hi += pump_dn ? 1 : 0;
            en_hi += pump_en ? 1 : 0;
        end
        w_up = ref_first ? lead + D : D;
        w_dn = ref_first ? D : lead + D;
        if (mode) begin
            check("R5 up_n held low", up_lo, len);
            check("R5 dn_n held low", dn_lo, len);
            check("R5 pump_en", en_hi, len);
            check("R5/R3 pump_up width", pu_hi, w_up);
            check("R5/R3 pump_dn width", pd_hi, w_dn);
        end else begin
            check(extra ? "R4/R1 up_n width" : "R1/R3 up_n width", up_lo, w_up);
            check(extra ? "R4/R2 dn_n width" : "R2/R3 dn_n width", dn_lo, w_dn);
            check("R6 pump idle", pu_hi + pd_hi + en_hi, 0);
        end
        // R7 width = lead; R8 count, R9 clear on a wide comparison
        if (lead <= THR) good_exp = (good_exp < LC) ? good_exp + 1 : LC;
        else             good_exp = 0;
        check(lead <= THR ? "R8 lock line" : "R9 lock line",
              int'(lock_pull_low), (good_exp < LC) ? 1 : 0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 up_n", int'(up_n), 1);
        check("R10 dn_n", int'(dn_n), 1);
        check("R10 pump", int'(pump_up) + int'(pump_dn), 0);
        check("R10 lock", int'(lock_pull_low), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // sweep leads in both directions in both modes
        for (int m = 0; m < 2; m++) begin
            for (int lead = 0; lead <= THR + 3; lead++) begin
                run_cmp(lead, 1'b1, m[0], 1'b0);
                if (lead > 0) run_cmp(lead, 1'b0, m[0], 1'b0);
            end
        end
        // ignored strobes, then a fresh lock build-up with exact count
        for (int lead = 2; lead <= THR; lead++) begin
            run_cmp(lead, 1'b1, 1'b0, 1'b1);
            run_cmp(lead, 1'b0, 1'b0, 1'b1);
        end
        run_cmp(THR + 1, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < LC + 1; k++) run_cmp(THR, 1'b0, 1'b0, 1'b0);
        run_cmp(THR + 2, 1'b0, 1'b1, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule